// File: doc/BRIEF.md
# Oscillator Wake-Up Delay Timer

This block keeps the CPU clock gated off after a reset or a wake-up event until the oscillator has had time to settle. It runs in the raw oscillator clock domain. The delay has two parts. First it counts a number of oscillator cycles, and that number depends on which clock source is selected. Then it counts a fixed number of ticks that arrive from an external timebase, which stands in for a settling time measured in microseconds.

Only when both parts have finished does the block raise its ready flag and enable the clock. The power controller raises a wake-up request when the part leaves a low-power state. A new request at any moment, including after the clock has been released, restarts the whole sequence from zero. The source select is captured once, when the sequence starts.

Top module: `osc_wake_timer`

## Requirements
- R1: While `rst_n` is low, `ready` and `clk_en` are 0 without waiting for a clock edge. After reset is released, a full delay runs without any wake-up request.
- R2: Select codes 0, 1 and 2 (crystal sources) give a cycle phase of `XTAL_CYCLES` oscillator cycles (default 992).
- R3: Select codes 3 (RC oscillator) and 4 (watchdog oscillator) give a cycle phase of `RC_CYCLES` cycles (default 224).
- R4: The unused select codes 5, 6 and 7 give the same cycle phase as the RC oscillator.
- R5: The tick phase counts `FIX_TICKS` pulses of `fix_tick` (default 80). Ticks are counted only after the cycle phase has ended, so ticks seen during the cycle phase have no effect.
- R6: The sequence starts at an origin edge o. This is the first rising edge after reset release, or a rising edge at which `wake_req` is sampled high. Ticks are counted at edges o+L+1 and later, where L is the cycle count. `ready` rises at the edge that samples the FIX_TICKS-th such tick, and `clk_en` always equals `ready`.
- R7: If `wake_req` is sampled high in any state, the sequence restarts at that edge and `ready` is 0 after it.
- R8: `src_sel` is sampled only at the origin edge. Changes to it later in the sequence do not alter the delay.
- R9: Once high, `ready` stays high until a wake-up request or a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Raw oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_req | input | 1 | Wake-up request; restarts the delay |
| src_sel | input | 3 | Clock source code: 0-2 crystal, 3 RC, 4 watchdog, others treated as RC |
| fix_tick | input | 1 | One-cycle tick from the fixed-time base |
| clk_en | output | 1 | Enable for the CPU clock gate |
| ready | output | 1 | Registered flag; the delay has completed |

## Verification
Every source code from 0 to 7 is run with a tick on every cycle. This separates the long crystal count from the short count used by codes 3 and 4 and by the unused codes. A sparse tick pattern, one tick every second or third cycle, shows whether ticks that fall in the cycle phase are wrongly counted. Wake-up requests are placed in the cycle phase, in the tick phase and after the ready flag has risen, to check that each one restarts the sequence from its own edge. Changes to the source select part-way through a sequence show whether the select is captured at the origin or leaks into the running count.

// File: rtl/osc_wake_timer.sv
module osc_wake_timer #(
  parameter int XTAL_CYCLES = 992,
  parameter int RC_CYCLES   = 224,
  parameter int FIX_TICKS   = 80
) (
  input  logic       clk_osc,
  input  logic       rst_n,
  input  logic       wake_req,
  input  logic [2:0] src_sel,
  input  logic       fix_tick,
  output logic       clk_en,
  output logic       ready
);

  localparam int MAXC = (XTAL_CYCLES > RC_CYCLES) ? XTAL_CYCLES : RC_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int TW   = $clog2(FIX_TICKS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CYC, ST_FIX, ST_RDY} state_t;

  state_t        st;
  logic [CW-1:0] cyc, lim;
  logic [TW-1:0] tck;
  logic [CW-1:0] sel_lim;

  assign sel_lim = (src_sel <= 3'd2) ? CW'(XTAL_CYCLES) : CW'(RC_CYCLES);
  assign clk_en  = ready;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cyc   <= '0;
      tck   <= '0;
      lim   <= '0;
      ready <= 1'b0;
    end else if (wake_req || st == ST_IDLE) begin
      st    <= ST_CYC;
      cyc   <= '0;
      tck   <= '0;
      lim   <= sel_lim;
      ready <= 1'b0;
    end else begin
      case (st)
        ST_CYC:
          if (cyc == lim - CW'(1)) st <= ST_FIX;
          else cyc <= cyc + CW'(1);
        ST_FIX:
          if (fix_tick) begin
            if (tck == TW'(FIX_TICKS - 1)) begin
              st    <= ST_RDY;
              ready <= 1'b1;
            end else begin
              tck <= tck + TW'(1);
            end
          end
        default: ;
      endcase
    end
  end

  // R7
  wake_clears_ready_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    wake_req |=> !ready);

  // R5
  rise_on_tick_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $rose(ready) |-> $past(fix_tick) && !$past(wake_req));

  // R9
  ready_hold_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    ready && !wake_req |=> ready);

  // R2
  cycle_bound_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    st == ST_CYC |-> cyc < lim);

  // R5
  tick_bound_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    st == ST_FIX |-> tck < TW'(FIX_TICKS));

  // R8
  limit_stable_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    st == ST_CYC && !wake_req |=> $stable(lim));

  // R6
  ready_state_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    ready |-> st == ST_RDY);

endmodule

// File: tb/osc_wake_timer_test.sv
module osc_wake_timer_test;
  localparam int PERIOD = 10;
  localparam int XT = 992;
  localparam int RC = 224;
  localparam int FT = 80;

  logic       clk_osc = 0;
  logic       rst_n = 0;
  logic       wake_req = 0;
  logic [2:0] src_sel = 0;
  logic       fix_tick = 0;
  logic       clk_en, ready;

  int checks = 0;
  int errors = 0;

  osc_wake_timer #(.XTAL_CYCLES(XT), .RC_CYCLES(RC), .FIX_TICKS(FT)) uut (
    .clk_osc(clk_osc), .rst_n(rst_n), .wake_req(wake_req), .src_sel(src_sel),
    .fix_tick(fix_tick), .clk_en(clk_en), .ready(ready));

  always #(PERIOD/2) clk_osc = ~clk_osc;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  function automatic int cyc_len(logic [2:0] s);
    return (s <= 3'd2) ? XT : RC;
  endfunction

  function automatic int ready_edge(int o, int len, int p);
    int n = 0;
    for (int e = o + len + 1; e < o + len + 1 + FT * p + p; e++) begin
      if (e % p == 0) n++;
      if (n == FT) return e;
    end
    return -1;
  endfunction

  task automatic run(string tag, logic [2:0] sel, int p, int restart_at,
                     logic [2:0] sel2, int chg_at);
    int e1, e2, last, bad_e, bad_a, bad_x;
    logic [2:0] sel_at_restart;
    bit en_bad;
    @(negedge clk_osc);
    #1 rst_n = 0;
    #1;
    checks++;
    if (ready !== 1'b0 || clk_en !== 1'b0) begin
      errors++;
      $display("FAIL R1 %s reset: actual ready=%b clk_en=%b expected 0 0", tag, ready, clk_en);
    end
    src_sel = sel;
    wake_req = 0;
    fix_tick = 0;
    @(negedge clk_osc);
    rst_n = 1;
    e1 = ready_edge(1, cyc_len(sel), p);
    sel_at_restart = (restart_at >= chg_at) ? sel2 : sel;
    e2 = (restart_at > 0) ? ready_edge(restart_at, cyc_len(sel_at_restart), p) : -1;
    last = ((restart_at > 0) ? e2 : e1) + 20;
    bad_e = -1; bad_a = 0; bad_x = 0; en_bad = 0;
    for (int e = 1; e <= last; e++) begin
      src_sel  = (e >= chg_at) ? sel2 : sel;
      wake_req = (e == restart_at);
      fix_tick = (e % p == 0);
      @(posedge clk_osc);
      @(negedge clk_osc);
      begin
        bit exp_r;
        if (restart_at > 0)
          exp_r = (e >= e1 && e < restart_at) || (e >= e2);
        else
          exp_r = (e >= e1);
        if (ready !== exp_r && bad_e < 0) begin
          bad_e = e; bad_a = ready; bad_x = exp_r;
        end
        if (clk_en !== ready) en_bad = 1;
      end
    end
    wake_req = 0;
    fix_tick = 0;
    checks++;
    if (bad_e >= 0) begin
      errors++;
      $display("FAIL %s timing at edge %0d: actual ready=%0d expected %0d", tag, bad_e, bad_a, bad_x);
    end
    checks++;
    if (en_bad) begin
      errors++;
      $display("FAIL R6 %s clk_en: actual differs from ready expected equal", tag);
    end
  endtask

  initial begin
    rst_n = 0;
    #(PERIOD * 3);
    // R2 R3 R4 R6 R9: every source code, tick every cycle
    for (int s = 0; s < 8; s++) begin
      if (s <= 2)      run($sformatf("R2 sel=%0d", s), 3'(s), 1, 0, 3'(s), 1 << 30);
      else if (s <= 4) run($sformatf("R3 sel=%0d", s), 3'(s), 1, 0, 3'(s), 1 << 30);
      else             run($sformatf("R4 sel=%0d", s), 3'(s), 1, 0, 3'(s), 1 << 30);
    end
    // R5: sparse ticks, ticks in the cycle phase ignored
    run("R5 sel=0 p=3", 3'd0, 3, 0, 3'd0, 1 << 30);
    run("R5 sel=3 p=2", 3'd3, 2, 0, 3'd3, 1 << 30);
    run("R5 sel=4 p=3", 3'd4, 3, 0, 3'd4, 1 << 30);
    // R7: restart in cycle phase, tick phase and ready
    run("R7 restart cycle", 3'd3, 1, 100, 3'd3, 1 << 30);
    run("R7 restart fixed", 3'd3, 1, 260, 3'd3, 1 << 30);
    run("R7 restart ready", 3'd4, 1, 320, 3'd4, 1 << 30);
    run("R7 restart xtal fixed p=2", 3'd1, 2, 1020, 3'd1, 1 << 30);
    // R8: select changes after origin ignored; new select taken at restart
    run("R8 xtal->rc midrun", 3'd0, 1, 0, 3'd3, 10);
    run("R8 rc->xtal midrun", 3'd3, 1, 0, 3'd2, 10);
    run("R8 select at restart", 3'd3, 1, 150, 3'd0, 50);
    summary();
    $finish;
  end
endmodule